// File: doc/BRIEF.md
# Dual Divided Clock Outputs with Runt-Free Stop

This block takes one fast internal clock and makes two divided output clocks, `qa` and `qb`. `qa` always runs at half the internal clock rate. `qb` runs either at the `qa` rate or at half of it, depending on a rate-select input. A single two-bit phase counter feeds both outputs, so their rising edges stay lined up.

Each output has its own active-high stop input, and a stop input may change at any time. The block passes each stop input through a short synchronizer. It then applies the change only at a phase of that output's own waveform where the change cannot cut a pulse short. A stopped output sits low.

The phase counter keeps running while an output is stopped. When the output restarts, it comes back in its old phase. The asynchronous master reset clears the counter, both outputs and both enable states at once. A pulse that was high when reset arrived is cut short.

Top module: `dual_clk_stop`

## Requirements
- R1: Once a stop input has been held high, its output is low from the fourth rising clock edge after the stop input rose, and it stays low while the stop input stays high.
- R2: Every high pulse is complete. `qa` is high for exactly one clock period. `qb` is high for one clock period when `half_b`=0 and for two clock periods when `half_b`=1. This holds while stops are being asserted and released.
- R3: Stopping or releasing one output does not disturb the other output, which keeps toggling at its normal rate.
- R4: `qa` toggles on every clock edge. With `half_b`=0, `qb` is identical to `qa`. With `half_b`=1, `qb` has a period of four clocks, giving 8 `qb` rising edges for every 16 `qa` rising edges. `half_b` is held steady except while reset is active.
- R5: After a stop input is released, `qa` produces its first pulse within 8 clock cycles and `qb` within 10. When both are released together with `half_b`=1, the first `qa` pulse may come before the first `qb` pulse, but never after it.
- R6: While `qa` is enabled, every rising edge of `qb` coincides with a rising edge of `qa`, in both rate modes, including after any sequence of stops and releases.
- R7: While `rst` is high, both outputs are low; asserting `rst` forces them low at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock that both outputs are derived from |
| rst | input | 1 | Asynchronous master reset, active high |
| half_b | input | 1 | 0: `qb` at the `qa` rate; 1: `qb` at half the `qa` rate |
| stop_a | input | 1 | Asynchronous stop request for `qa`, active high |
| stop_b | input | 1 | Asynchronous stop request for `qb`, active high |
| qa | output | 1 | First divided clock output |
| qb | output | 1 | Second divided clock output |

## Verification
Three kinds of internal fault show up at the ports, each within a few clock cycles.

- **Enable state changing at the wrong phase.** The output shows a high run that is shorter or longer than its nominal width, in the cycle where the stop or release is applied.
- **Counter phase slipping or being disturbed by a stop.** A `qb` rising edge lands in a cycle where `qa` did not rise, on the very next `qb` pulse.
- **Synchronizer or release path stuck.** The output either keeps toggling past the stop deadline or never returns within the restart deadline.

// File: rtl/dual_clk_stop.sv
module dual_clk_stop #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic half_b,
  input  logic stop_a,
  input  logic stop_b,
  output logic qa,
  output logic qb
);

  logic [1:0] cnt;
  logic [1:0] cnt_n;
  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic en_a, en_b, en_a_n, en_b_n;
  logic sa, sb;
  logic ra_c, ra_n, rb_c, rb_n;

  assign cnt_n = cnt + 2'd1;
  assign ra_c  = ~cnt[0];
  assign ra_n  = ~cnt_n[0];
  assign rb_c  = half_b ? ~cnt[1]   : ~cnt[0];
  assign rb_n  = half_b ? ~cnt_n[1] : ~cnt_n[0];
  assign sa    = sync_a[SYNC_STAGES-1];
  assign sb    = sync_b[SYNC_STAGES-1];

  // stop: drop enable unless a pulse is in progress; release: only at a rising point
  assign en_a_n = sa ? (en_a & ra_n & ra_c) : (en_a | (ra_n & ~ra_c));
  assign en_b_n = sb ? (en_b & rb_n & rb_c) : (en_b | (rb_n & ~rb_c));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= 2'b00;
      sync_a <= '0;
      sync_b <= '0;
      en_a   <= 1'b0;
      en_b   <= 1'b0;
      qa     <= 1'b0;
      qb     <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      sync_a <= {sync_a[SYNC_STAGES-2:0], stop_a};
      sync_b <= {sync_b[SYNC_STAGES-2:0], stop_b};
      en_a   <= en_a_n;
      en_b   <= en_b_n;
      qa     <= ra_n & en_a_n;
      qb     <= rb_n & en_b_n;
    end
  end

  AST_STOP_A_PARKS: assert property (@(posedge clk) disable iff (rst)
    (sa && $past(sa) && $past(sa, 2)) |-> !qa); // R1

  AST_B_HALF_FULL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (half_b && $rose(qb)) |=> qb); // R2

  AST_A_RISE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(qa) |-> !cnt[0]); // R6

  AST_B_HALF_RISE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (half_b && $rose(qb)) |-> (cnt == 2'b00)); // R6

  AST_EQUAL_MODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!half_b && en_a && en_b) |-> (qa == qb)); // R4

endmodule

// File: tb/tb_dual_clk_stop.sv
`timescale 1ns/1ps
module tb_dual_clk_stop;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_b = 1'b0;
  logic stop_a = 1'b0;
  logic stop_b = 1'b0;
  logic qa, qb;

  int checks = 0;
  int errors = 0;
  bit mon = 1'b0;
  bit align = 1'b0;
  bit done = 1'b0;
  logic pa = 1'b0, pb = 1'b0;
  int wa = 0, wb = 0;

  always #4 clk = ~clk;

  dual_clk_stop dut (.clk(clk), .rst(rst), .half_b(half_b), .stop_a(stop_a),
                     .stop_b(stop_b), .qa(qa), .qb(qb));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pulse-width and alignment monitor (R2, R6)
  always @(negedge clk) begin
    if (mon) begin
      if (pa && !qa) chk(wa == 1, "R2 qa width", wa, 1);
      if (pb && !qb) chk(wb == (half_b ? 2 : 1), "R2 qb width", wb, half_b ? 2 : 1);
      if (align && !pb && qb) chk(!pa && qa, "R6 qb rise without qa rise", int'(qa), 1);
    end
    wa = qa ? wa + 1 : 0;
    wb = qb ? wb + 1 : 0;
    pa = qa;
    pb = qb;
  end

  task automatic do_reset(input bit h);
    mon = 1'b0;
    align = 1'b0;
    @(negedge clk);
    #1 rst = 1'b1;
    half_b = h;
    stop_a = 1'b0;
    stop_b = 1'b0;
    #1 chk(!qa && !qb, "R7 reset low", {qa, qb}, 0);
    repeat (3) @(negedge clk);
    chk(!qa && !qb, "R7 held low", {qa, qb}, 0);
    #1 rst = 1'b0;
    repeat (8) @(negedge clk);
    mon = 1'b1;
  endtask

  task automatic t_equal();
    logic prev;
    do_reset(1'b0);
    align = 1'b1;
    prev = qa;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk(qa == qb, "R4 equal mode", qb, qa);
      chk(qa != prev, "R4 qa toggles", qa, !prev);
      prev = qa;
    end
  endtask

  task automatic t_half();
    int ra, rb;
    do_reset(1'b1);
    align = 1'b1;
    ra = 0; rb = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (!pa && qa) ra++;
      if (!pb && qb) rb++;
    end
    chk(ra == 16, "R4 qa rises", ra, 16);
    chk(rb == 8, "R4 qb half-rate rises", rb, 8);
  endtask

  task automatic t_stop_a(input bit h, input int off);
    int rb, lowbad, k;
    do_reset(h);
    @(negedge clk);
    #(off) stop_a = 1'b1;
    repeat (4) @(negedge clk);
    rb = 0; lowbad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (qa) lowbad++;
      if (!pb && qb) rb++;
    end
    chk(lowbad == 0, "R1 qa parked low", lowbad, 0);
    chk(rb == (h ? 3 : 6), "R3 qb unaffected by stop_a", rb, h ? 3 : 6);
    #(off) stop_a = 1'b0;
    k = 0;
    while (!qa && k < 8) begin @(negedge clk); k++; end
    chk(qa, "R5 qa restarts", k, 8);
    align = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_stop_b(input bit h, input int off);
    int ra, lowbad, k;
    do_reset(h);
    align = 1'b1;
    @(negedge clk);
    #(off) stop_b = 1'b1;
    repeat (4) @(negedge clk);
    ra = 0; lowbad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (qb) lowbad++;
      if (!pa && qa) ra++;
    end
    chk(lowbad == 0, "R1 qb parked low", lowbad, 0);
    chk(ra == 6, "R3 qa unaffected by stop_b", ra, 6);
    #(off) stop_b = 1'b0;
    k = 0;
    while (!qb && k < 10) begin @(negedge clk); k++; end
    chk(qb, "R5 qb restarts", k, 10);
    repeat (16) @(negedge clk);
  endtask

  task automatic t_both_release();
    int fa, fb;
    do_reset(1'b1);
    stop_a = 1'b1;
    stop_b = 1'b1;
    repeat (10) @(negedge clk);
    chk(!qa && !qb, "R1 both parked", {qa, qb}, 0);
    align = 1'b1;
    #2 stop_a = 1'b0;
    stop_b = 1'b0;
    fa = -1; fb = -1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (qa && fa < 0) fa = i;
      if (qb && fb < 0) fb = i;
    end
    chk(fb >= 0, "R5 qb restarts after joint release", fb, 0);
    chk(fa >= 0 && fa <= fb, "R5 qa not later than qb", fa, fb);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset_mid();
    int k;
    do_reset(1'b1);
    k = 0;
    while (!(qa && qb) && k < 8) begin @(negedge clk); k++; end
    mon = 1'b0;
    #1 rst = 1'b1;
    #1 chk(!qa && !qb, "R7 async reset cuts pulse", {qa, qb}, 0);
    repeat (2) @(negedge clk);
    chk(!qa && !qb, "R7 low while reset", {qa, qb}, 0);
    #1 rst = 1'b0;
  endtask

  initial begin
    t_equal();
    t_half();
    t_stop_a(1'b0, 1);
    t_stop_a(1'b1, 3);
    t_stop_b(1'b0, 2);
    t_stop_b(1'b1, 1);
    t_stop_b(1'b1, 3);
    t_both_release();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule